// File: doc/BRIEF.md
# Destination ID Acceptance Filter

This block sits on the receive path of a serial packet endpoint, after the transport layer and before the logical layer. It looks at the routing header of every arriving packet and decides whether the packet is kept. The decision uses the transport-type code, the destination ID and the transaction kind. These are compared against a programmable local device ID and a programmable group (multicast) ID. Kept packets go out on a valid/ready stream with their payload and header address left exactly as they arrived. Rejected packets are taken from the input and discarded.

A single mode bit selects between two acceptance policies. In the strict policy only packets addressed to the local device ID get through. In the open policy, group-addressed packets are accepted as well. Group traffic cannot ask for a reply, so group hits are kept only when they are response-free writes. Those packets are tagged so that they can be steered to the memory access engine. A group hit of any other kind is discarded and counted.

The decision is made on the first beat of each packet (the header beat). It then holds for every later beat up to and including the beat marked last.

Top module: `rio_dest_filter`

## Requirements
- R1: After reset, outValid is 0 and dropCount is 0, and the first beat presented is treated as a header beat.
- R2: With transport code 2'b00 (small IDs), only bits [7:0] of the destination ID are compared, against bits [7:0] of each configured ID. Bits [15:8] of all three are ignored.
- R3: With transport code 2'b01 (large IDs), all 16 bits of the destination ID are compared against all 16 bits of the configured ID.
- R4: A header with transport code 2'b10 or 2'b11 is discarded, whatever its IDs.
- R5: A packet that matches the local ID is accepted for any transaction kind. Every beat appears on the output with data and last unchanged and outMcast at 0.
- R6: With cfgMcastEn at 0, a packet that matches only the group ID is discarded and dropCount does not change.
- R7: With cfgMcastEn at 1, a packet that matches only the group ID is accepted with outMcast at 1 on every beat when it is a response-free write. Two kinds qualify: NWRITE (ftype 5 with ttype 4) and SWRITE (ftype 6 with any ttype).
- R8: With cfgMcastEn at 1, a packet that matches only the group ID but is any other kind is discarded, and dropCount rises by exactly one per such packet.
- R9: The header-beat decision applies to every following beat up to the beat with inLast at 1. Header inputs presented on later beats have no effect.
- R10: For a discarded beat, inReady is 1 regardless of outReady. For an accepted beat, inReady equals outReady.
- R11: When the destination matches both configured IDs, the local match wins: the packet is accepted with outMcast at 0 for any transaction kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgLocalId | input | 16 | Local device ID |
| cfgMcastId | input | 16 | Group (multicast) ID |
| cfgMcastEn | input | 1 | 1 = also accept group traffic |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat taken |
| inData | input | DATA_W | Input beat payload |
| inLast | input | 1 | Final beat of the packet |
| inTt | input | 2 | Transport code (header beat) |
| inDestId | input | 16 | Destination ID (header beat) |
| inFtype | input | 4 | Format type (header beat) |
| inTtype | input | 4 | Transaction subtype (header beat) |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream can take a beat |
| outData | output | DATA_W | Output beat payload |
| outLast | output | 1 | Final beat of the packet |
| outMcast | output | 1 | Beat belongs to an accepted group write |
| dropCount | output | CNT_W | Count of rejected group non-writes, saturating |

## Verification
The bench sweeps both policies, all four transport codes, five destination choices and five transaction kinds, over packets one to three beats long. Several of the destinations match only in the low byte; a filter that compared the wrong width would pass or reject exactly those. Body beats carry junk header fields, so a filter that re-decided on every beat would break packets apart. Directed cases cover a destination equal to both IDs, where a wrong priority would tag a local read as group traffic, and backpressure, where a filter that stalled discarded beats would hang the input.

// File: rtl/rio_filter_pkg.sv
package rio_filter_pkg;
  localparam int ID_W = 16;
  localparam logic [3:0] FT_NWRITE = 4'd5;
  localparam logic [3:0] TT_NWRITE = 4'd4;
  localparam logic [3:0] FT_SWRITE = 4'd6;

  typedef enum logic [1:0] {
    TT_SMALL = 2'b00,
    TT_LARGE = 2'b01,
    TT_RSVD2 = 2'b10,
    TT_RSVD3 = 2'b11
  } ttCode_e;

  typedef struct packed {
    logic passBeat;
    logic mcastTag;
    logic bumpDrop;
  } ctrlStrobes_t;
endpackage

// File: rtl/rio_id_compare.sv
module rio_id_compare
  import rio_filter_pkg::*;
(
  input  logic [1:0]      tt,
  input  logic [ID_W-1:0] destId,
  input  logic [ID_W-1:0] refId,
  output logic            hit
);
  localparam int SMALL_W = ID_W / 2;

  always_comb begin
    unique case (ttCode_e'(tt))
      TT_SMALL: hit = (destId[SMALL_W-1:0] == refId[SMALL_W-1:0]);
      TT_LARGE: hit = (destId == refId);
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/rio_filter_ctrl.sv
module rio_filter_ctrl
  import rio_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   cfgLocalId,
  input  logic [ID_W-1:0]   cfgMcastId,
  input  logic              cfgMcastEn,
  input  logic              inValid,
  input  logic              inLast,
  input  logic [1:0]        inTt,
  input  logic [ID_W-1:0]   inDestId,
  input  logic [3:0]        inFtype,
  input  logic [3:0]        inTtype,
  input  logic              outReady,
  output logic              inReady,
  output ctrlStrobes_t      strobes
);
  localparam int NUM_IDS = 2;

  logic [ID_W-1:0] refIds [NUM_IDS];
  logic [NUM_IDS-1:0] idHits;

  assign refIds[0] = cfgLocalId;
  assign refIds[1] = cfgMcastId;

  for (genvar g = 0; g < NUM_IDS; g++) begin : gCmp
    rio_id_compare uCmp (
      .tt    (inTt),
      .destId(inDestId),
      .refId (refIds[g]),
      .hit   (idHits[g])
    );
  end

  logic inPkt, keepReg, mcastReg;
  logic hdrBeat, ucHit, mcHit, isWrite, hdrKeep, hdrMcast, curKeep, fire;

  assign hdrBeat  = !inPkt;
  assign ucHit    = idHits[0];
  assign mcHit    = idHits[1] && !ucHit;
  assign isWrite  = (inFtype == FT_NWRITE && inTtype == TT_NWRITE) || (inFtype == FT_SWRITE);
  assign hdrMcast = cfgMcastEn && mcHit && isWrite;
  assign hdrKeep  = ucHit || hdrMcast;
  assign curKeep  = hdrBeat ? hdrKeep : keepReg;

  assign inReady = curKeep ? outReady : 1'b1;
  assign fire    = inValid && inReady;

  assign strobes.passBeat = inValid && curKeep;
  assign strobes.mcastTag = hdrBeat ? hdrMcast : mcastReg;
  assign strobes.bumpDrop = fire && hdrBeat && cfgMcastEn && mcHit && !isWrite;

  always_ff @(posedge clk) begin
    if (rst) begin
      inPkt    <= 1'b0;
      keepReg  <= 1'b0;
      mcastReg <= 1'b0;
    end else if (fire) begin
      if (inLast) begin
        inPkt <= 1'b0;
      end else begin
        inPkt <= 1'b1;
        if (hdrBeat) begin
          keepReg  <= hdrKeep;
          mcastReg <= hdrMcast;
        end
      end
    end
  end
endmodule

// File: rtl/rio_filter_datapath.sv
module rio_filter_datapath
  import rio_filter_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic              outMcast,
  output logic [CNT_W-1:0]  dropCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign outValid = strobes.passBeat;
  assign outData  = inData;
  assign outLast  = inLast;
  assign outMcast = strobes.passBeat && strobes.mcastTag;

  always_ff @(posedge clk) begin
    if (rst) begin
      dropCount <= '0;
    end else if (strobes.bumpDrop && dropCount != CNT_MAX) begin
      dropCount <= dropCount + 1'b1;
    end
  end
endmodule

// File: rtl/rio_dest_filter.sv
module rio_dest_filter
  import rio_filter_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cfgLocalId,
  input  logic [15:0]       cfgMcastId,
  input  logic              cfgMcastEn,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  input  logic [1:0]        inTt,
  input  logic [15:0]       inDestId,
  input  logic [3:0]        inFtype,
  input  logic [3:0]        inTtype,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic              outMcast,
  output logic [CNT_W-1:0]  dropCount
);
  ctrlStrobes_t strobes;

  rio_filter_ctrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .cfgLocalId(cfgLocalId),
    .cfgMcastId(cfgMcastId),
    .cfgMcastEn(cfgMcastEn),
    .inValid   (inValid),
    .inLast    (inLast),
    .inTt      (inTt),
    .inDestId  (inDestId),
    .inFtype   (inFtype),
    .inTtype   (inTtype),
    .outReady  (outReady),
    .inReady   (inReady),
    .strobes   (strobes)
  );

  rio_filter_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uData (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .inData   (inData),
    .inLast   (inLast),
    .outValid (outValid),
    .outData  (outData),
    .outLast  (outLast),
    .outMcast (outMcast),
    .dropCount(dropCount)
  );
endmodule

// File: rtl/rio_dest_filter_chk.sv
module rio_dest_filter_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfgMcastEn,
  input logic              inValid,
  input logic              inReady,
  input logic [DATA_W-1:0] inData,
  input logic              inLast,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              outLast,
  input logic              outMcast,
  input logic [CNT_W-1:0]  dropCount
);
  // R5: forwarded beats carry payload and last flag unchanged
  assert_passthrough_R5: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outData == inData && outLast == inLast && inValid));

  // R6: strict policy never tags group traffic
  assert_strict_no_group_R6: assert property (@(posedge clk) disable iff (rst)
    !cfgMcastEn |-> !outMcast);

  // R7: group tag only rides on a forwarded beat
  assert_tag_on_beat_R7: assert property (@(posedge clk) disable iff (rst)
    outMcast |-> outValid);

  // R8: drop count steps by at most one and never falls
  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dropCount == $past(dropCount) || dropCount == $past(dropCount) + 1'b1));

  // R10: discarded beats are always taken
  assert_drop_taken_R10: assert property (@(posedge clk) disable iff (rst)
    (inValid && !outValid) |-> inReady);

  // R10: forwarded beats follow downstream backpressure
  assert_backpressure_R10: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (inReady == outReady));
endmodule

bind rio_dest_filter rio_dest_filter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rst       (rst),
  .cfgMcastEn(cfgMcastEn),
  .inValid   (inValid),
  .inReady   (inReady),
  .inData    (inData),
  .inLast    (inLast),
  .outValid  (outValid),
  .outReady  (outReady),
  .outData   (outData),
  .outLast   (outLast),
  .outMcast  (outMcast),
  .dropCount (dropCount)
);

// File: tb/sim_rio_dest_filter.sv
`timescale 1ns/1ps
module sim_rio_dest_filter;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] cfgLocalId = 16'hA53C;
  logic [15:0] cfgMcastId = 16'h5AC3;
  logic cfgMcastEn = 1'b0;
  logic inValid = 1'b0, inReady, inLast = 1'b0, outValid, outReady = 1'b1;
  logic outLast, outMcast;
  logic [DATA_W-1:0] inData = '0, outData;
  logic [1:0] inTt = 2'b00;
  logic [15:0] inDestId = '0;
  logic [3:0] inFtype = '0, inTtype = '0;
  logic [CNT_W-1:0] dropCount;

  int errors = 0;
  int checks = 0;
  int expDrops = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rio_dest_filter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .cfgLocalId(cfgLocalId), .cfgMcastId(cfgMcastId),
    .cfgMcastEn(cfgMcastEn), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inLast(inLast), .inTt(inTt), .inDestId(inDestId), .inFtype(inFtype),
    .inTtype(inTtype), .outValid(outValid), .outReady(outReady), .outData(outData),
    .outLast(outLast), .outMcast(outMcast), .dropCount(dropCount)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit idHit(input logic [1:0] tt, input logic [15:0] d, input logic [15:0] r);
    if (tt == 2'b00) return d[7:0] == r[7:0];
    if (tt == 2'b01) return d == r;
    return 1'b0;
  endfunction

  // One beat: drive at the falling edge, sample 1 ns later, commit at the rising edge
  task automatic beat(input logic [1:0] tt, input logic [15:0] dest, input logic [3:0] ft,
                      input logic [3:0] tp, input logic [31:0] data, input logic last,
                      input bit expKeep, input bit expMc, input string req);
    @(negedge clk);
    inValid = 1'b1; inTt = tt; inDestId = dest; inFtype = ft; inTtype = tp;
    inData = data; inLast = last;
    #1;
    check(outValid === expKeep, req, "outValid", longint'(outValid), longint'(expKeep));
    check(inReady === (expKeep ? outReady : 1'b1), req, "inReady", longint'(inReady),
          longint'(expKeep ? outReady : 1'b1));
    if (expKeep) begin
      check(outData === data && outLast === last && outMcast === expMc, req,
            "data/last/mcast", longint'({outData, outLast, outMcast}), longint'({data, last, expMc}));
    end
    @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  // Full packet; body beats carry junk header fields (R9)
  task automatic packet(input logic [1:0] tt, input logic [15:0] dest, input logic [3:0] ft,
                        input logic [3:0] tp, input int len, input string req);
    bit uc = idHit(tt, dest, cfgLocalId);
    bit mc = !uc && idHit(tt, dest, cfgMcastId);
    bit wr = (ft == 4'd5 && tp == 4'd4) || ft == 4'd6;
    bit keep = uc || (cfgMcastEn && mc && wr);
    bit tag = !uc && cfgMcastEn && mc && wr;
    if (cfgMcastEn && mc && !wr) expDrops++;
    for (int b = 0; b < len; b++) begin
      if (b == 0)
        beat(tt, dest, ft, tp, 32'hC0DE0000 + 32'(b), len == 1, keep, tag, req);
      else
        beat(2'(~tt), ~dest, 4'(~ft), 4'(~tp), 32'hB0D70000 + 32'(b), b == len - 1,
             keep, tag, "R9");
    end
    #1;
    check(dropCount === CNT_W'(expDrops), "R8", "dropCount", longint'(dropCount),
          longint'(expDrops));
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] dests [5];
    logic [3:0] fts [5];
    logic [3:0] tps [5];
    string req;
    int idx = 0;
    repeat (3) @(posedge clk);
    #1;
    check(outValid === 1'b0 && dropCount === '0, "R1", "reset outValid/dropCount",
          longint'({outValid, dropCount}), 0);
    rst = 1'b0;

    // R1: first beat after reset is a header beat (unicast, 1 beat)
    packet(2'b01, 16'hA53C, 4'd2, 4'd4, 1, "R1");

    dests[0] = 16'hA53C; dests[1] = 16'hFF3C; dests[2] = 16'h5AC3;
    dests[3] = 16'h00C3; dests[4] = 16'h1234;
    fts[0] = 4'd5; tps[0] = 4'd4;
    fts[1] = 4'd5; tps[1] = 4'd5;
    fts[2] = 4'd6; tps[2] = 4'd0;
    fts[3] = 4'd2; tps[3] = 4'd4;
    fts[4] = 4'd8; tps[4] = 4'd0;

    for (int m = 0; m < 2; m++) begin
      cfgMcastEn = m[0];
      for (int t = 0; t < 4; t++) begin
        for (int d = 0; d < 5; d++) begin
          for (int k = 0; k < 5; k++) begin
            if (t >= 2) req = "R4";
            else if (d == 1 || d == 3) req = (t == 0) ? "R2" : "R3";
            else if (idHit(2'(t), dests[d], cfgLocalId)) req = "R5";
            else if (!idHit(2'(t), dests[d], cfgMcastId)) req = "R3";
            else if (m == 0) req = "R6";
            else if (k == 0 || k == 2) req = "R7";
            else req = "R8";
            packet(2'(t), dests[d], fts[k], tps[k], 1 + (idx % 3), req);
            idx++;
          end
        end
      end
    end

    // R10: accepted beat stalls under backpressure, discarded beat does not
    cfgMcastEn = 1'b1;
    outReady = 1'b0;
    beat(2'b01, 16'hA53C, 4'd2, 4'd4, 32'h11110000, 1'b1, 1'b1, 1'b0, "R10");
    beat(2'b01, 16'h1234, 4'd2, 4'd4, 32'h22220000, 1'b1, 1'b0, 1'b0, "R10");
    outReady = 1'b1;
    packet(2'b01, 16'hA53C, 4'd2, 4'd4, 1, "R10");

    // R11: destination equal to both IDs: local match wins
    cfgMcastId = cfgLocalId;
    packet(2'b01, 16'hA53C, 4'd2, 4'd4, 2, "R11");
    packet(2'b00, 16'h773C, 4'd6, 4'd0, 2, "R11");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule